// File: doc/BRIEF.md
# Auto-Masking Priority Interrupt Controller

This block gathers level-sensitive interrupt requests for one processor and presents the most urgent one through a single event word. Two groups of sources feed it: a parameterised number of ordinary hardware lines and a small group of fast lines, such as timer outputs. Every source has a mask bit and a software-trigger bit. The trigger bit is ORed with the source's input line, so software can raise any interrupt with no hardware involved.

When software reads the event word, the reported source is delivered and its mask bit is set on the same clock edge. The source therefore stays quiet until software has serviced it and unmasks it again with a mask-clear write. Priority is fixed. A pending fast source always beats a hardware source, and inside each group the lowest number wins. A one-bit processor interrupt output stays high for as long as any source is pending and unmasked.

Writes use one strobe, a two-bit operation code and a data word. The data word names the target source by its group and number, so each write acts on exactly one source. Event reads have their own strobe, which means a read and a write can happen in the same cycle.

Top module: `irq_automask_ctrl`

## Requirements
- R1: After reset every mask bit is set, every software-trigger bit is clear, `cpu_irq` is low and `ev_data` reads zero, even while input lines are high.
- R2: A hardware or fast input that is high and unmasked is pending. It stops being pending in the cycle its line falls, unless its trigger bit is set.
- R3: A masked source never appears in `ev_data`. A write with `wr_op`=1 (mask clear) to a source clears its mask from the next cycle on. A write with `wr_op`=0 (mask set) sets it.
- R4: A write with `wr_op`=2 sets the source's trigger bit and makes the source pending while its line is low. A write with `wr_op`=3 clears the trigger bit.
- R5: Among pending hardware sources, the one with the lowest number is reported.
- R6: Any pending fast source is reported ahead of every hardware source, and the lowest fast number wins among fast sources.
- R7: `ev_data` has the valid flag in bit 31, the group in bits [17:16] (0 = hardware, 1 = fast), the number in bits [15:0] and zeros elsewhere. It reads all zeros when nothing is pending.
- R8: A cycle with `ev_rd` high and a valid event sets the reported source's mask bit on that clock edge. From the next cycle on, the next pending source is reported.
- R9: `cpu_irq` equals the valid flag of `ev_data` and falls in the cycle after the last pending source is delivered.
- R10: When an event read and a mask-clear write to the delivered source fall in the same cycle, the source ends up masked.
- R11: A write whose group field (`wr_data[17:16]`) is neither 0 nor 1, or whose number (`wr_data[15:0]`) is beyond its group's count, changes no mask or trigger bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | N_HW | Level hardware interrupt lines, active high |
| fast_irq | input | N_FAST | Level fast interrupt lines (timers), active high |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 mask set, 1 mask clear, 2 trigger set, 3 trigger clear |
| wr_data | input | 32 | [17:16] group, [15:0] source number |
| ev_rd | input | 1 | Event read strobe; delivers and masks the reported source |
| ev_data | output | 32 | Current event word |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The embedded assertions check on every cycle that each delivery masks its source, including when a mask-clear write hits the same source in that cycle. They also check that the reported hardware number has no pending source below it, that fast sources win over hardware ones, that a masked source is never reported, that the event word keeps its layout, and that `cpu_irq` matches the OR of the pending requests. Some behaviour only the bench scenarios can show. These are the reset state while lines are held high, how a level that falls withdraws its event, how the trigger bits take effect, the sequence of events across successive reads, and that writes with an out-of-range number or an unknown group leave every source untouched.

// File: rtl/irq_automask_pkg.sv
`timescale 1ns/1ps
package irq_automask_pkg;

   localparam int unsigned NUM_W  = 16;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      KIND_HW   = 2'd0,
      KIND_FAST = 2'd1
   } src_kind_e;

   typedef enum logic [1:0] {
      OP_MASK_SET = 2'd0,
      OP_MASK_CLR = 2'd1,
      OP_TRIG_SET = 2'd2,
      OP_TRIG_CLR = 2'd3
   } wr_op_e;

   function automatic logic [WORD_W-1:0] make_event(input logic       vld,
                                                    input logic [1:0] kind,
                                                    input logic [NUM_W-1:0] num);
      logic [WORD_W-1:0] w;
      w = '0;
      if (vld) begin
         w[31]    = 1'b1;
         w[17:16] = kind;
         w[15:0]  = num;
      end
      return w;
   endfunction

endpackage

// File: rtl/irq_line_bank.sv
`timescale 1ns/1ps
module irq_line_bank
   import irq_automask_pkg::*;
#(
   parameter int unsigned LINES = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_in,
   input  logic             wr_sel,
   input  logic [1:0]       wr_op,
   input  logic [NUM_W-1:0] wr_num,
   input  logic             ack_en,
   input  logic [IDX_W-1:0] ack_idx,
   output logic [LINES-1:0] req,
   output logic [LINES-1:0] mask_q,
   output logic [LINES-1:0] trig_q
);

   generate
      if (LINES < 1 || LINES > (1 << NUM_W)) begin : g_bad_lines
         $error("irq_line_bank: LINES out of range");
      end
      if ((1 << IDX_W) < LINES) begin : g_bad_idx
         $error("irq_line_bank: IDX_W too narrow for LINES");
      end
   endgenerate

   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         logic hit;
         logic m_set, m_clr, t_set, t_clr;
         logic m_r, t_r;

         assign hit   = wr_sel && (wr_num == NUM_W'(g));
         assign m_set = (hit && op == OP_MASK_SET) ||
                        (ack_en && ack_idx == IDX_W'(g));
         assign m_clr = hit && op == OP_MASK_CLR;
         assign t_set = hit && op == OP_TRIG_SET;
         assign t_clr = hit && op == OP_TRIG_CLR;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m_r <= 1'b1;
               t_r <= 1'b0;
            end else begin
               if (m_set)      m_r <= 1'b1;
               else if (m_clr) m_r <= 1'b0;
               if (t_set)      t_r <= 1'b1;
               else if (t_clr) t_r <= 1'b0;
            end
         end

         assign mask_q[g] = m_r;
         assign trig_q[g] = t_r;
         assign req[g]    = (line_in[g] | t_r) & ~m_r;

         // R8
         ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_en && ack_idx == IDX_W'(g)) |=> m_r);

         // R10
         ack_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_en && ack_idx == IDX_W'(g) && m_clr) |=> m_r);

         // R3
         clear_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_clr && !(ack_en && ack_idx == IDX_W'(g))) |=> !m_r);

         // R4
         trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            t_set |=> t_r);
      end
   endgenerate

endmodule

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
module irq_lowest_pick #(
   parameter int unsigned LINES     = 4,
   parameter int unsigned IDX_W     = 2,
   parameter bit          ISO_STYLE = 1'b1
) (
   input  logic [LINES-1:0] req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   generate
      if ((1 << IDX_W) < LINES) begin : g_bad_idx
         $error("irq_lowest_pick: IDX_W too narrow for LINES");
      end
   endgenerate

   assign found = |req;

   generate
      if (ISO_STYLE) begin : g_iso
         logic [LINES-1:0] low1;
         assign low1 = req & (~req + LINES'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < LINES; i++) begin
               if (low1[i]) idx = idx | IDX_W'(i);
            end
         end
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = LINES - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_automask_ctrl.sv
`timescale 1ns/1ps
module irq_automask_ctrl
   import irq_automask_pkg::*;
#(
   parameter int unsigned N_HW        = 24,
   parameter int unsigned N_FAST      = 4,
   parameter bit          PICK_ISO    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HW-1:0]   hw_irq,
   input  logic [N_FAST-1:0] fast_irq,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [31:0]       wr_data,
   input  logic              ev_rd,
   output logic [31:0]       ev_data,
   output logic              cpu_irq
);

   localparam int unsigned HW_IDX_W = (N_HW   > 1) ? $clog2(N_HW)   : 1;
   localparam int unsigned FS_IDX_W = (N_FAST > 1) ? $clog2(N_FAST) : 1;

   generate
      if (N_HW < 1 || N_HW > (1 << NUM_W)) begin : g_bad_hw
         $error("irq_automask_ctrl: N_HW out of range");
      end
      if (N_FAST < 1 || N_FAST > (1 << NUM_W)) begin : g_bad_fast
         $error("irq_automask_ctrl: N_FAST out of range");
      end
   endgenerate

   // write routing by group field
   src_kind_e        wr_kind;
   logic             hw_wr, fs_wr;
   logic [NUM_W-1:0] wr_num;

   assign wr_kind = src_kind_e'(wr_data[17:16]);
   assign wr_num  = wr_data[NUM_W-1:0];
   assign hw_wr   = wr_en && (wr_kind == KIND_HW);
   assign fs_wr   = wr_en && (wr_kind == KIND_FAST);

   logic [N_HW-1:0]     h_req, h_mask, h_trig;
   logic [N_FAST-1:0]   f_req, f_mask, f_trig;
   logic                h_found, f_found;
   logic [HW_IDX_W-1:0] h_idx;
   logic [FS_IDX_W-1:0] f_idx;
   logic                ack_h, ack_f;

   irq_line_bank #(.LINES(N_FAST), .IDX_W(FS_IDX_W)) u_fast_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (fast_irq),
      .wr_sel  (fs_wr),
      .wr_op   (wr_op),
      .wr_num  (wr_num),
      .ack_en  (ack_f),
      .ack_idx (f_idx),
      .req     (f_req),
      .mask_q  (f_mask),
      .trig_q  (f_trig)
   );

   irq_line_bank #(.LINES(N_HW), .IDX_W(HW_IDX_W)) u_hw_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (hw_irq),
      .wr_sel  (hw_wr),
      .wr_op   (wr_op),
      .wr_num  (wr_num),
      .ack_en  (ack_h),
      .ack_idx (h_idx),
      .req     (h_req),
      .mask_q  (h_mask),
      .trig_q  (h_trig)
   );

   irq_lowest_pick #(.LINES(N_FAST), .IDX_W(FS_IDX_W), .ISO_STYLE(PICK_ISO)) u_fast_pick (
      .req   (f_req),
      .found (f_found),
      .idx   (f_idx)
   );

   irq_lowest_pick #(.LINES(N_HW), .IDX_W(HW_IDX_W), .ISO_STYLE(PICK_ISO)) u_hw_pick (
      .req   (h_req),
      .found (h_found),
      .idx   (h_idx)
   );

   // event word and delivery
   logic             ev_vld;
   src_kind_e        ev_kind;
   logic [NUM_W-1:0] ev_num;

   assign ev_vld  = f_found | h_found;
   assign ev_kind = f_found ? KIND_FAST : KIND_HW;
   assign ev_num  = f_found ? NUM_W'(f_idx) : NUM_W'(h_idx);
   assign ev_data = make_event(ev_vld, ev_kind, ev_num);
   assign cpu_irq = ev_vld;

   assign ack_f = ev_rd && f_found;
   assign ack_h = ev_rd && !f_found && h_found;

   // R5
   lowest_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_found |-> (h_req[h_idx] &&
                   ((h_req & ((N_HW'(1) << h_idx) - N_HW'(1))) == '0)));

   // R6
   fast_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|f_req) |-> (ev_data[17:16] == 2'd1 && f_req[ev_data[FS_IDX_W-1:0]]));

   // R3
   masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_data[31] && ev_data[17:16] == 2'd0) |-> !h_mask[h_idx]);

   // R7
   word_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_data[30:18] == '0) && (ev_data[31] || ev_data == '0));

   // R9
   irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == ((|((hw_irq | h_trig) & ~h_mask)) ||
                  (|((fast_irq | f_trig) & ~f_mask))));

endmodule

// File: tb/sim_irq_automask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_automask_ctrl;

   localparam int NH = 24;
   localparam int NF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NH-1:0] hw_irq = '0;
   logic [NF-1:0] fast_irq = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_op = 2'd0;
   logic [31:0]   wr_data = '0;
   logic          ev_rd = 1'b0;
   logic [31:0]   ev_data;
   logic          cpu_irq;

   always #5 clk = ~clk;

   irq_automask_ctrl #(.N_HW(NH), .N_FAST(NF)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .fast_irq(fast_irq),
      .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
      .ev_rd(ev_rd), .ev_data(ev_data), .cpu_irq(cpu_irq)
   );

   // reference state
   bit [NH-1:0] m_mh, m_th;
   bit [NF-1:0] m_mf, m_tf;
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur    = "R1";

   function automatic logic [31:0] ref_event();
      for (int i = 0; i < NF; i++)
         if ((fast_irq[i] || m_tf[i]) && !m_mf[i])
            return {1'b1, 13'd0, 2'd1, 16'(i)};
      for (int i = 0; i < NH; i++)
         if ((hw_irq[i] || m_th[i]) && !m_mh[i])
            return {1'b1, 13'd0, 2'd0, 16'(i)};
      return 32'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ref_reset();
      m_mh = '1; m_th = '0; m_mf = '1; m_tf = '0;
   endtask

   task automatic ref_edge(input logic [31:0] e);
      int unsigned k, n;
      if (!rst_n) begin
         ref_reset();
         return;
      end
      if (wr_en) begin
         k = wr_data[17:16];
         n = wr_data[15:0];
         if (k == 0 && n < NH) begin
            case (wr_op)
               2'd0: m_mh[n] = 1'b1;
               2'd1: m_mh[n] = 1'b0;
               2'd2: m_th[n] = 1'b1;
               default: m_th[n] = 1'b0;
            endcase
         end else if (k == 1 && n < NF) begin
            case (wr_op)
               2'd0: m_mf[n] = 1'b1;
               2'd1: m_mf[n] = 1'b0;
               2'd2: m_tf[n] = 1'b1;
               default: m_tf[n] = 1'b0;
            endcase
         end
      end
      if (ev_rd && e[31]) begin
         if (e[17:16] == 2'd1) m_mf[e[15:0]] = 1'b1;
         else                  m_mh[e[15:0]] = 1'b1;
      end
   endtask

   // one cycle: compare away from the edge, then advance the model
   task automatic cyc();
      logic [31:0] e;
      #2;
      e = ref_event();
      chk({cur, " event"}, ev_data, e);
      chk({cur, " R9 irq"}, {31'd0, cpu_irq}, {31'd0, e[31]});
      @(posedge clk);
      ref_edge(e);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] op, input logic [1:0] kind, input logic [15:0] num);
      wr_en = 1'b1; wr_op = op; wr_data = {14'd0, kind, num};
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd();
      ev_rd = 1'b1;
      cyc();
      ev_rd = 1'b0;
   endtask

   task automatic expect_word(input string tag, input logic [31:0] exp);
      #1;
      chk(tag, ev_data, exp);
   endtask

   initial begin
      ref_reset();
      hw_irq = '1;
      @(posedge clk);
      @(negedge clk);
      // R1: lines high during and after reset, everything masked
      cur = "R1";
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      expect_word("R1 masked after reset", 32'h0);

      // R3: open line 5 while all lines high, then close it
      cur = "R3";
      wr(2'd1, 2'd0, 16'd5);
      expect_word("R3 unmasked line 5", 32'h8000_0005);
      wr(2'd0, 2'd0, 16'd5);
      expect_word("R3 remasked line 5", 32'h0);
      hw_irq = '0;
      cyc();

      // R2: level behaviour
      cur = "R2";
      wr(2'd1, 2'd0, 16'd3);
      wr(2'd1, 2'd0, 16'd10);
      cyc();
      hw_irq[10] = 1'b1; cyc();
      expect_word("R2 line 10 pending", 32'h8000_000A);
      hw_irq[10] = 1'b0; cyc();
      expect_word("R2 line 10 withdrawn", 32'h0);

      // R5: lowest hardware number wins
      cur = "R5";
      hw_irq[10] = 1'b1; hw_irq[3] = 1'b1; cyc();
      expect_word("R5 lowest wins", 32'h8000_0003);

      // R8 / R9: successive reads deliver and mask
      cur = "R8";
      rd();
      expect_word("R8 next event after read", 32'h8000_000A);
      rd();
      expect_word("R9 nothing left", 32'h0);
      cyc();

      // R4: software trigger with the line low
      cur = "R4";
      hw_irq = '0;
      wr(2'd1, 2'd0, 16'd7);
      cyc();
      wr(2'd2, 2'd0, 16'd7);
      expect_word("R4 trigger raises 7", 32'h8000_0007);
      wr(2'd3, 2'd0, 16'd7);
      expect_word("R4 trigger cleared", 32'h0);

      // R6 / R7: fast group precedence and word layout
      cur = "R6";
      wr(2'd2, 2'd0, 16'd7);
      wr(2'd1, 2'd1, 16'd1);
      wr(2'd1, 2'd1, 16'd2);
      fast_irq = 4'b0100; cyc();
      expect_word("R6 fast 2 over hw 7", 32'h8001_0002);
      fast_irq = 4'b0110; cyc();
      expect_word("R7 fast 1 word", 32'h8001_0001);
      rd();
      expect_word("R6 fast 2 after read", 32'h8001_0002);

      // R10: read and mask clear of the same source in one cycle
      cur = "R10";
      ev_rd = 1'b1;
      wr(2'd1, 2'd1, 16'd2);
      ev_rd = 1'b0;
      expect_word("R10 auto-mask wins", 32'h8000_0007);
      cyc();

      // R11: writes with bad numbers or groups change nothing
      cur = "R11";
      wr(2'd3, 2'd0, 16'd7);
      fast_irq = 4'b0001;
      hw_irq = '0; hw_irq[0] = 1'b1;
      cyc();
      wr(2'd1, 2'd0, 16'd32);
      wr(2'd1, 2'd0, 16'd24);
      wr(2'd1, 2'd1, 16'd4);
      wr(2'd1, 2'd2, 16'd0);
      wr(2'd1, 2'd3, 16'd0);
      wr(2'd2, 2'd2, 16'd1);
      expect_word("R11 nothing opened", 32'h0);
      wr(2'd1, 2'd0, 16'd0);
      expect_word("R11 line 0 still reachable", 32'h8000_0000);
      wr(2'd1, 2'd1, 16'd0);
      expect_word("R6 fast 0 first", 32'h8001_0000);
      rd(); rd();
      expect_word("R9 drained", 32'h0);
      cyc();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule